// File: doc/BRIEF.md
# Leveled Priority Interrupt Controller

This block collects up to 63 level-sensitive interrupt request lines and offers the processor one pending request: the most urgent one. Requests fall into seven urgency levels, numbered 1 to 7, with 7 the most urgent. Within a level, nine ranked slots decide which request wins. Fifty-six sources carry a programmable level and a programmable in-level priority. Sources 1 to 7 are tied to the level equal to their number. Each of those fixed sources sits in the slot between programmable priorities 3 and 4.

Software sets each source through a one-cycle write port. One write carries a level, a priority and a mask bit together. The processor watches the registered level output. When that output is non-zero, the processor acknowledges a level and gets back the vector of the request that wins at that level. If nothing is pending at the acknowledged level, it gets a spurious vector. Acknowledging clears nothing: a request stays pending for as long as its input line is high.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset `cur_level_o` is 0 and `ack_rsp_o` is 0. Every source is masked. Every programmable source has level 0.
- R2: `cur_level_o` is the highest level that holds an eligible pending source, or 0 if there is none. It is registered, so it follows request inputs after one clock edge and follows a configuration write after two edges.
- R3: A source is eligible only while all three conditions hold: its `irq_i` bit is 1, its mask bit is 0 (1 means masked), and its level is non-zero. Programmed level 0 disables a source.
- R4: Sources 1 to 7 are fixed at level n for source n. A configuration write to one of them updates only its mask bit. The level and priority fields of that write have no effect.
- R5: Within one level, a higher slot rank wins. A programmable priority p (0 to 7) has rank p when p < 4 and rank p+1 when p >= 4. A fixed source has rank 4.
- R6: If two eligible sources have equal level and equal rank, the lower source number wins.
- R7: One clock edge after `ack_valid_i` is sampled high, `ack_rsp_o` is 1 and `ack_vector_o` is 64 plus the number of the source that wins at `ack_level_i`. `ack_rsp_o` is 0 in every cycle after a cycle with no acknowledge.
- R8: An acknowledge returns vector 24 if no eligible source is pending at the acknowledged level. An acknowledge of level 0 always returns 24.
- R9: Requests are level-sensitive. Acknowledging does not clear a request, so a repeated acknowledge returns the same vector. Lowering the input line withdraws the request.
- R10: Source 0 does not exist. A write to index 0 and bit 0 of `irq_i` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_i | input | 64 | Request lines; bit n is source n; bit 0 is unused |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_src_i | input | 6 | Source number being written |
| cfg_level_i | input | 3 | Level to store (0 disables the source) |
| cfg_prio_i | input | 3 | In-level priority to store |
| cfg_mask_i | input | 1 | Mask bit to store (1 = masked) |
| ack_valid_i | input | 1 | Acknowledge strobe |
| ack_level_i | input | 3 | Level being acknowledged |
| cur_level_o | output | 3 | Highest level with an eligible pending request |
| ack_rsp_o | output | 1 | Acknowledge response valid |
| ack_vector_o | output | 8 | Vector returned for the acknowledge |

## Verification
The bound checker tests four things on every clock cycle. It confirms that the acknowledge response follows the strobe by exactly one edge. It confirms that every returned vector is either the spurious code or lies in the source range. It confirms that an acknowledge of level 0 returns the spurious code. It confirms that an idle request bus gives level 0, and that an unmasked top fixed source forces the top level. The bench scenarios cover the rest: slot ranking around the fixed slot, breaking ties by source number, disabling a source through level 0, ignored fields on fixed sources and on source 0, and level-sensitive persistence across repeated acknowledges. Random configuration and request traffic is then checked against a reference model.

// File: rtl/intc_pkg.sv
package intc_pkg;

    typedef struct packed {
        logic [2:0] lvl;
        logic [2:0] prio;
        logic       mask;
    } src_cfg_t;

endpackage

// File: rtl/intc_cfg_regs.sv
module intc_cfg_regs
    import intc_pkg::*;
#(
    parameter int NSRC   = 64,
    parameter int NFIXED = 7,
    localparam int SRC_W = $clog2(NSRC)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we_i,
    input  logic [SRC_W-1:0]       src_i,
    input  logic [2:0]             lvl_i,
    input  logic [2:0]             prio_i,
    input  logic                   mask_i,
    output src_cfg_t [NSRC-1:0]    cfg_o
);

    src_cfg_t [NSRC-1:0] cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we_i && src_i != '0) begin
            cfg_d[src_i].mask = mask_i;
            if (int'(src_i) > NFIXED) begin
                cfg_d[src_i].lvl  = lvl_i;
                cfg_d[src_i].prio = prio_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < NSRC; s++) begin
                cfg_q[s].mask <= 1'b1;
                cfg_q[s].prio <= '0;
                cfg_q[s].lvl  <= (s >= 1 && s <= NFIXED) ? 3'(s) : 3'd0;
            end
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg_o = cfg_q;

endmodule

// File: rtl/intc_level_arb.sv
module intc_level_arb
    import intc_pkg::*;
#(
    parameter int NSRC       = 64,
    parameter int NFIXED     = 7,
    parameter int LEVEL      = 1,
    parameter int FIXED_RANK = 4,
    localparam int SRC_W     = $clog2(NSRC)
) (
    input  logic [NSRC-1:0]        irq_i,
    input  src_cfg_t [NSRC-1:0]    cfg_i,
    output logic                   hit_o,
    output logic [SRC_W-1:0]       src_o
);

    logic [3:0] best_rank;
    logic [3:0] rank;
    logic       elig;

    always_comb begin
        hit_o     = 1'b0;
        src_o     = '0;
        best_rank = '0;
        rank      = '0;
        elig      = 1'b0;
        for (int s = 0; s < NSRC; s++) begin
            elig = (s != 0) && irq_i[s] && !cfg_i[s].mask
                   && (cfg_i[s].lvl == 3'(LEVEL));
            if (s >= 1 && s <= NFIXED)
                rank = 4'(FIXED_RANK);
            else if (int'(cfg_i[s].prio) < FIXED_RANK)
                rank = {1'b0, cfg_i[s].prio};
            else
                rank = {1'b0, cfg_i[s].prio} + 4'd1;
            if (elig && (!hit_o || rank > best_rank)) begin
                hit_o     = 1'b1;
                best_rank = rank;
                src_o     = SRC_W'(s);
            end
        end
    end

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import intc_pkg::*;
#(
    parameter int NSRC       = 64,
    parameter int NLVL       = 7,
    parameter int NFIXED     = 7,
    parameter int FIXED_RANK = 4,
    parameter int VEC_BASE   = 64,
    parameter int SPUR_VEC   = 24,
    localparam int SRC_W     = $clog2(NSRC),
    localparam int LVL_W     = $clog2(NLVL + 1),
    localparam int VEC_W     = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NSRC-1:0]    irq_i,
    input  logic               cfg_we_i,
    input  logic [SRC_W-1:0]   cfg_src_i,
    input  logic [2:0]         cfg_level_i,
    input  logic [2:0]         cfg_prio_i,
    input  logic               cfg_mask_i,
    input  logic               ack_valid_i,
    input  logic [LVL_W-1:0]   ack_level_i,
    output logic [LVL_W-1:0]   cur_level_o,
    output logic               ack_rsp_o,
    output logic [VEC_W-1:0]   ack_vector_o
);

    typedef struct packed {
        logic [LVL_W-1:0] cur_lvl;
        logic             ack_rsp;
        logic [VEC_W-1:0] ack_vec;
    } state_t;

    state_t st_d, st_q;

    src_cfg_t [NSRC-1:0] cfg_w;
    logic [(1<<LVL_W)-1:0] lvl_hit;
    logic [SRC_W-1:0]      lvl_src [1<<LVL_W];

    intc_cfg_regs #(.NSRC(NSRC), .NFIXED(NFIXED)) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_i   (cfg_we_i),
        .src_i  (cfg_src_i),
        .lvl_i  (cfg_level_i),
        .prio_i (cfg_prio_i),
        .mask_i (cfg_mask_i),
        .cfg_o  (cfg_w)
    );

    assign lvl_hit[0] = 1'b0;
    assign lvl_src[0] = '0;

    for (genvar l = 1; l < (1 << LVL_W); l++) begin : g_lvl
        if (l <= NLVL) begin : g_arb
            intc_level_arb #(
                .NSRC(NSRC), .NFIXED(NFIXED),
                .LEVEL(l), .FIXED_RANK(FIXED_RANK)
            ) u_arb (
                .irq_i (irq_i),
                .cfg_i (cfg_w),
                .hit_o (lvl_hit[l]),
                .src_o (lvl_src[l])
            );
        end else begin : g_none
            assign lvl_hit[l] = 1'b0;
            assign lvl_src[l] = '0;
        end
    end

    always_comb begin
        st_d         = st_q;
        st_d.cur_lvl = '0;
        for (int l = 1; l <= NLVL; l++)
            if (lvl_hit[l]) st_d.cur_lvl = LVL_W'(l);
        st_d.ack_rsp = ack_valid_i;
        if (ack_valid_i) begin
            if (ack_level_i != '0 && lvl_hit[ack_level_i])
                st_d.ack_vec = VEC_W'(VEC_BASE) + VEC_W'(lvl_src[ack_level_i]);
            else
                st_d.ack_vec = VEC_W'(SPUR_VEC);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cur_level_o  = st_q.cur_lvl;
    assign ack_rsp_o    = st_q.ack_rsp;
    assign ack_vector_o = st_q.ack_vec;

endmodule

// File: rtl/intc_chk.sv
module intc_chk
    import intc_pkg::*;
#(
    parameter int NSRC     = 64,
    parameter int NFIXED   = 7,
    parameter int VEC_BASE = 64,
    parameter int SPUR_VEC = 24
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NSRC-1:0]     irq_i,
    input src_cfg_t [NSRC-1:0] cfg_i,
    input logic                ack_valid_i,
    input logic [2:0]          ack_level_i,
    input logic [2:0]          cur_level_o,
    input logic                ack_rsp_o,
    input logic [7:0]          ack_vector_o
);

    a_r7_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid_i |=> ack_rsp_o);

    a_r7_no_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_valid_i |=> !ack_rsp_o);

    a_r7_vec_range: assert property (@(posedge clk) disable iff (!rst_n)
        ack_rsp_o |-> (ack_vector_o == 8'(SPUR_VEC)) ||
                      (ack_vector_o > 8'(VEC_BASE) && ack_vector_o < 8'(VEC_BASE + NSRC)));

    a_r8_lvl0_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid_i && ack_level_i == 3'd0) |=> ack_vector_o == 8'(SPUR_VEC));

    a_r3_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_i[NSRC-1:1] == '0) |=> cur_level_o == 3'd0);

    a_r4_fixed_top: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_i[NFIXED] && !cfg_i[NFIXED].mask) |=> cur_level_o == 3'(NFIXED));

endmodule

bind prio_irq_ctrl intc_chk #(
    .NSRC(NSRC), .NFIXED(NFIXED), .VEC_BASE(VEC_BASE), .SPUR_VEC(SPUR_VEC)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .irq_i        (irq_i),
    .cfg_i        (cfg_w),
    .ack_valid_i  (ack_valid_i),
    .ack_level_i  (ack_level_i),
    .cur_level_o  (cur_level_o),
    .ack_rsp_o    (ack_rsp_o),
    .ack_vector_o (ack_vector_o)
);

// File: tb/sim_prio_irq_ctrl.sv
`timescale 1ns/1ps
module sim_prio_irq_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] irq = '0;
    logic        cfg_we = 1'b0;
    logic [5:0]  cfg_src = '0;
    logic [2:0]  cfg_level = '0;
    logic [2:0]  cfg_prio = '0;
    logic        cfg_mask = 1'b0;
    logic        ack_valid = 1'b0;
    logic [2:0]  ack_level = '0;
    logic [2:0]  cur_level;
    logic        ack_rsp;
    logic [7:0]  ack_vector;

    int checks = 0;
    int failures = 0;

    int m_lvl  [64];
    int m_prio [64];
    int m_mask [64];

    always #2.5 clk = ~clk;

    prio_irq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .irq_i(irq),
        .cfg_we_i(cfg_we), .cfg_src_i(cfg_src), .cfg_level_i(cfg_level),
        .cfg_prio_i(cfg_prio), .cfg_mask_i(cfg_mask),
        .ack_valid_i(ack_valid), .ack_level_i(ack_level),
        .cur_level_o(cur_level), .ack_rsp_o(ack_rsp), .ack_vector_o(ack_vector)
    );

    function automatic int rank_of(int s);
        if (s >= 1 && s <= 7) return 4;
        return (m_prio[s] < 4) ? m_prio[s] : m_prio[s] + 1;
    endfunction

    function automatic int win_src(int l);
        int best = 0;
        int br = -1;
        if (l == 0) return 0;
        for (int s = 1; s < 64; s++) begin
            if (irq[s] && m_mask[s] == 0 && m_lvl[s] == l && rank_of(s) > br) begin
                br = rank_of(s);
                best = s;
            end
        end
        return best;
    endfunction

    function automatic int exp_vec(int l);
        int w = win_src(l);
        return (w == 0) ? 24 : 64 + w;
    endfunction

    function automatic int exp_top();
        int t = 0;
        for (int l = 1; l <= 7; l++) if (win_src(l) != 0) t = l;
        return t;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int s = 0; s < 64; s++) begin
            m_lvl[s]  = (s >= 1 && s <= 7) ? s : 0;
            m_prio[s] = 0;
            m_mask[s] = 1;
        end
    endtask

    task automatic wr(input int s, input int l, input int p, input int m);
        cfg_we = 1'b1; cfg_src = 6'(s); cfg_level = 3'(l);
        cfg_prio = 3'(p); cfg_mask = 1'(m);
        @(negedge clk);
        cfg_we = 1'b0;
        if (s != 0) begin
            m_mask[s] = m;
            if (s > 7) begin m_lvl[s] = l; m_prio[s] = p; end
        end
    endtask

    task automatic chk_level(input string tag);
        @(negedge clk);
        chk(cur_level == 3'(exp_top()), tag, cur_level, exp_top());
    endtask

    task automatic do_ack(input int l, input string tag);
        int e;
        e = exp_vec(l);
        ack_valid = 1'b1; ack_level = 3'(l);
        @(negedge clk);
        ack_valid = 1'b0;
        chk(ack_rsp == 1'b1, {tag, " rsp"}, ack_rsp, 1);
        chk(ack_vector == 8'(e), tag, ack_vector, e);
    endtask

    initial begin
        #1000000;
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int v1;
        void'($urandom(32'd5151));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cur_level == 3'd0, "R1 reset level", cur_level, 0);
        chk(ack_rsp == 1'b0, "R1 reset rsp", ack_rsp, 0);
        irq = '1;
        chk_level("R1 all masked");
        chk(cur_level == 3'd0, "R3 masked idle", cur_level, 0);
        irq = '0;
        @(negedge clk);

        // R4: fixed source 5 at level 5; level/prio fields of its write ignored
        wr(5, 2, 7, 0);
        irq[5] = 1'b1;
        chk_level("R4 fixed level");
        chk(cur_level == 3'd5, "R4 fixed is 5", cur_level, 5);
        do_ack(5, "R7 fixed vector");
        do_ack(2, "R4 no move to 2");

        // R5: prio 4 ranks above fixed slot, prio 3 below
        wr(20, 5, 4, 0);
        irq[20] = 1'b1;
        chk_level("R2 level after write");
        do_ack(5, "R5 prio4 beats fixed");
        chk(ack_vector == 8'd84, "R5 expect src20", ack_vector, 84);
        wr(20, 5, 3, 0);
        @(negedge clk);
        do_ack(5, "R5 fixed beats prio3");
        chk(ack_vector == 8'd69, "R5 expect src5", ack_vector, 69);

        // R6: tie lower number wins
        wr(30, 6, 2, 0);
        wr(40, 6, 2, 0);
        irq[30] = 1'b1; irq[40] = 1'b1;
        chk_level("R2 level six");
        do_ack(6, "R6 tie");
        chk(ack_vector == 8'd94, "R6 expect src30", ack_vector, 94);

        // R9: repeat ack gives same vector; drop irq withdraws
        do_ack(6, "R9 repeat ack");
        chk(ack_vector == 8'd94, "R9 still src30", ack_vector, 94);
        irq[30] = 1'b0;
        @(negedge clk);
        do_ack(6, "R9 after drop");

        // R3: level 0 disables source 40
        wr(40, 0, 2, 0);
        @(negedge clk);
        do_ack(6, "R3 disabled src");
        chk(ack_vector == 8'd24, "R8 empty level", ack_vector, 24);
        chk(cur_level == 3'd5, "R2 back to 5", cur_level, 5);
        do_ack(0, "R8 level zero");

        // R10: source 0 ignored
        irq[0] = 1'b1;
        wr(0, 7, 7, 0);
        chk_level("R10 src0 ignored");
        chk(cur_level == 3'd5, "R10 level 5", cur_level, 5);
        // R7: no rsp without ack
        chk(ack_rsp == 1'b0, "R7 no rsp idle", ack_rsp, 0);

        // random traffic
        for (int it = 0; it < 400; it++) begin
            if ($urandom % 2 == 0)
                wr($urandom % 64, $urandom % 8, $urandom % 8, ($urandom % 4 == 0) ? 1 : 0);
            irq = {$urandom, $urandom};
            chk_level("R2 random level");
            v1 = $urandom % 8;
            do_ack(v1, "R7 random ack");
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule